// File: doc/BRIEF.md
# Range-Matched Lookup Table

This block is a lookup memory whose rows are selected by address ranges rather than by exact addresses. Each row holds a range-start value and a data word. The start values rise strictly from row to row. An incoming address picks the single row whose range contains it, and that row's word appears on the outputs. The word is split into a mantissa code, a second-base exponent and a binary-exponent correction. A typical use is the final stage of a binary to single-digit two-dimensional logarithmic converter. There, a normalised mantissa is rounded to the nearest exactly representable value.

Each row has only one greater-or-equal comparator. The upper bound of a row's range comes from the next row's comparison, inverted. The row count, the address width, the field widths and the whole table are parameters. A parameter chooses between a registered output with one cycle of latency and a purely combinational path. The reset is asynchronous and active low. Its release is synchronised inside the block.

Top module: `rl_ralut`

## Requirements
- R1: While the synchronised reset is active, all three outputs read zero. Asserting `rst_n` low clears them without waiting for a clock edge.
- R2: With the registered variant, the outputs one clock after an address is presented hold row n's fields. Row n is the row with START[n] <= address < START[n+1].
- R3: Any address greater than or equal to the last row's start value selects the last row.
- R4: Any address below the first row's start value selects row 0.
- R5: An address exactly equal to START[n] selects row n. The address START[n]-1 selects row n-1.
- R6: For every address exactly one row is enabled, so the output is always one stored word, unmixed.
- R7: When the address stays constant, the outputs stay constant.
- R8: The output word is packed as {mantissa code, b exponent, e exponent}, from the most significant field down. The three ports expose these fields in that order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_i | input | ADDR_W | Lookup address (normalised mantissa fraction) |
| mant_o | output | MANT_W | Mantissa code of the selected row |
| bexp_o | output | BEXP_W | Second-base exponent of the selected row |
| eexp_o | output | EEXP_W | Binary-exponent correction of the selected row |

## Verification
With the default registered variant, every lookup result is due exactly one rising edge after its address is sampled. The bench drives a new address on each falling edge. On the next falling edge it compares the outputs with the row that a behavioural search found for the address it drove one cycle earlier. The reset result is due at once, without any edge, so it is sampled a step after `rst_n` falls. After release, two edges pass through the synchroniser before any lookup is compared.

// File: rtl/rl_pkg.sv
package rl_pkg;

  localparam int DEF_ROWS   = 9;
  localparam int DEF_ADDR_W = 10;
  localparam int DEF_MANT_W = 10;
  localparam int DEF_BEXP_W = 4;
  localparam int DEF_EEXP_W = 4;
  localparam int DEF_DATA_W = DEF_MANT_W + DEF_BEXP_W + DEF_EEXP_W;

  function automatic logic [DEF_DATA_W-1:0] mk_word(int mant, int bexp, int eexp);
    logic [DEF_MANT_W-1:0] m;
    logic [DEF_BEXP_W-1:0] b;
    logic [DEF_EEXP_W-1:0] e;
    m = DEF_MANT_W'(mant);
    b = DEF_BEXP_W'(bexp);
    e = DEF_EEXP_W'(eexp);
    return {m, b, e};
  endfunction

  localparam logic [DEF_ADDR_W-1:0] DEF_START [DEF_ROWS] = '{
    10'd16, 10'd80, 10'd190, 10'd300, 10'd410,
    10'd520, 10'd640, 10'd770, 10'd1000
  };

  localparam logic [DEF_DATA_W-1:0] DEF_DATA [DEF_ROWS] = '{
    mk_word(0,   0,  0), mk_word(64,  3, -4), mk_word(180, -2, 3),
    mk_word(290, 1, -1), mk_word(400, 4, -6), mk_word(512, -1, 2),
    mk_word(700, 2, -3), mk_word(820, 5, -7), mk_word(0,   0,  1)
  };

endpackage

// File: rtl/rl_ge_bank.sv
module rl_ge_bank #(
  parameter int ROWS   = rl_pkg::DEF_ROWS,
  parameter int ADDR_W = rl_pkg::DEF_ADDR_W,
  parameter logic [ADDR_W-1:0] START [ROWS] = rl_pkg::DEF_START
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ROWS-1:0]   ge_o
);

  // One lower-bound comparator per row; row 0 is the catch-all floor.
  for (genvar n = 0; n < ROWS; n++) begin : g_cmp
    if (n == 0) begin : g_floor
      assign ge_o[n] = 1'b1;
    end else begin : g_ge
      assign ge_o[n] = (addr_i >= START[n]);
    end
  end

endmodule

// File: rtl/rl_row_select.sv
module rl_row_select #(
  parameter int ROWS = rl_pkg::DEF_ROWS
) (
  input  logic [ROWS-1:0] ge_i,
  output logic [ROWS-1:0] match_o
);

  // Upper bound of a row is the inverted comparison of its upper neighbour.
  for (genvar n = 0; n < ROWS; n++) begin : g_sel
    if (n == ROWS - 1) begin : g_top
      assign match_o[n] = ge_i[n];
    end else begin : g_mid
      assign match_o[n] = ge_i[n] & ~ge_i[n+1];
    end
  end

endmodule

// File: rtl/rl_word_mux.sv
module rl_word_mux #(
  parameter int ROWS   = rl_pkg::DEF_ROWS,
  parameter int DATA_W = rl_pkg::DEF_DATA_W,
  parameter logic [DATA_W-1:0] DATA [ROWS] = rl_pkg::DEF_DATA
) (
  input  logic [ROWS-1:0]   match_i,
  output logic [DATA_W-1:0] word_o
);

  always_comb begin
    word_o = '0;
    for (int n = 0; n < ROWS; n++) begin
      word_o = word_o | (DATA[n] & {DATA_W{match_i[n]}});
    end
  end

endmodule

// File: rtl/rl_ralut.sv
module rl_ralut #(
  parameter int ROWS    = rl_pkg::DEF_ROWS,
  parameter int ADDR_W  = rl_pkg::DEF_ADDR_W,
  parameter int MANT_W  = rl_pkg::DEF_MANT_W,
  parameter int BEXP_W  = rl_pkg::DEF_BEXP_W,
  parameter int EEXP_W  = rl_pkg::DEF_EEXP_W,
  parameter bit REG_OUT = 1'b1,
  parameter logic [ADDR_W-1:0] START [ROWS] = rl_pkg::DEF_START,
  parameter logic [MANT_W+BEXP_W+EEXP_W-1:0] DATA [ROWS] = rl_pkg::DEF_DATA
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [MANT_W-1:0] mant_o,
  output logic [BEXP_W-1:0] bexp_o,
  output logic [EEXP_W-1:0] eexp_o
);

  localparam int DATA_W = MANT_W + BEXP_W + EEXP_W;

  logic [ROWS-1:0]   ge;
  logic [ROWS-1:0]   match;
  logic [DATA_W-1:0] word_d;
  logic [DATA_W-1:0] word_q;
  logic [1:0]        rst_sync;
  logic              rst_q_n;

  // Reset asserts at once, releases after two clock edges.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q_n = rst_sync[1];

  rl_ge_bank #(.ROWS(ROWS), .ADDR_W(ADDR_W), .START(START)) u_ge (
    .addr_i (addr_i),
    .ge_o   (ge)
  );

  rl_row_select #(.ROWS(ROWS)) u_sel (
    .ge_i    (ge),
    .match_o (match)
  );

  rl_word_mux #(.ROWS(ROWS), .DATA_W(DATA_W), .DATA(DATA)) u_mux (
    .match_i (match),
    .word_o  (word_d)
  );

  if (REG_OUT) begin : g_reg
    logic [DATA_W-1:0] word_next;
    always_comb begin
      word_next = word_d;
    end
    always_ff @(posedge clk or negedge rst_q_n) begin
      if (!rst_q_n) word_q <= '0;
      else          word_q <= word_next;
    end
  end else begin : g_comb
    always_comb begin
      word_q = rst_q_n ? word_d : '0;
    end
  end

  assign {mant_o, bexp_o, eexp_o} = word_q;

endmodule

// File: rtl/rl_ralut_chk.sv
module rl_ralut_chk #(
  parameter int ROWS   = rl_pkg::DEF_ROWS,
  parameter int ADDR_W = rl_pkg::DEF_ADDR_W,
  parameter int DATA_W = rl_pkg::DEF_DATA_W,
  parameter logic [ADDR_W-1:0] START [ROWS] = rl_pkg::DEF_START,
  parameter logic [DATA_W-1:0] DATA [ROWS] = rl_pkg::DEF_DATA
) (
  input logic              clk,
  input logic              rst_q_n,
  input logic [ADDR_W-1:0] addr_i,
  input logic [ROWS-1:0]   match,
  input logic [DATA_W-1:0] word_q
);

  function automatic bit in_table(logic [DATA_W-1:0] w);
    bit hit = 1'b0;
    for (int n = 0; n < ROWS; n++) if (DATA[n] == w) hit = 1'b1;
    return hit;
  endfunction

  a_r1_reset_zero: assert property (@(posedge clk)
    !rst_q_n |-> (word_q == '0));

  a_r6_one_row: assert property (@(posedge clk) disable iff (!rst_q_n)
    $countones(match) == 1);

  a_r6_word_stored: assert property (@(posedge clk) disable iff (!rst_q_n)
    $past(rst_q_n) |-> in_table(word_q));

  a_r3_top_row: assert property (@(posedge clk) disable iff (!rst_q_n)
    (addr_i >= START[ROWS-1]) |=> (word_q == DATA[ROWS-1]));

  a_r4_floor_row: assert property (@(posedge clk) disable iff (!rst_q_n)
    (addr_i < START[0]) |=> (word_q == DATA[0]));

  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_q_n)
    ($past(rst_q_n) && $stable(addr_i)) |=> $stable(word_q));

endmodule

bind rl_ralut rl_ralut_chk #(
  .ROWS(ROWS), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .START(START), .DATA(DATA)
) u_chk (
  .clk     (clk),
  .rst_q_n (rst_q_n),
  .addr_i  (addr_i),
  .match   (match),
  .word_q  (word_q)
);

// File: tb/tb_rl_ralut.sv
module tb_rl_ralut;
  import rl_pkg::*;

  localparam int ROWS = DEF_ROWS;
  localparam int AW   = DEF_ADDR_W;
  localparam int DW   = DEF_DATA_W;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] addr;
  logic [DEF_MANT_W-1:0] mant;
  logic [DEF_BEXP_W-1:0] bexp;
  logic [DEF_EEXP_W-1:0] eexp;

  int checks = 0;
  int fails  = 0;
  logic [DW-1:0] exp_word;
  string         exp_tag;

  always #5 clk = ~clk;

  rl_ralut dut (
    .clk(clk), .rst_n(rst_n), .addr_i(addr),
    .mant_o(mant), .bexp_o(bexp), .eexp_o(eexp)
  );

  function automatic int ref_row(int a);
    int sel = 0;
    for (int n = 0; n < ROWS; n++) if (a >= int'(DEF_START[n])) sel = n;
    return sel;
  endfunction

  function automatic string tag_of(int a);
    if (a < int'(DEF_START[0])) return "R4";
    if (a >= int'(DEF_START[ROWS-1])) return "R3";
    for (int n = 1; n < ROWS; n++) begin
      if (a == int'(DEF_START[n]) || a == int'(DEF_START[n]) - 1) return "R5";
    end
    return "R2";
  endfunction

  task automatic check(string req, logic [DW-1:0] got, logic [DW-1:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // Compare last cycle's expectation, then drive a new address.
  task automatic step(int a);
    @(negedge clk);
    check(exp_tag, {mant, bexp, eexp}, exp_word);
    addr     = AW'(a);
    exp_word = DEF_DATA[ref_row(a)];
    exp_tag  = tag_of(a);
  endtask

  initial begin
    #(20000 * 10);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    addr  = '0;
    repeat (3) @(negedge clk);
    check("R1", {mant, bexp, eexp}, '0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    addr     = AW'(500);
    exp_word = DEF_DATA[ref_row(500)];
    exp_tag  = "R2";

    // Full sweep, ascending: covers R2, R3, R4, R5, R6.
    for (int a = 0; a < (1 << AW); a++) step(a);
    // Descending boundary walk.
    for (int n = ROWS - 1; n >= 1; n--) begin
      step(int'(DEF_START[n]));
      step(int'(DEF_START[n]) - 1);
    end
    // R7: constant address keeps outputs constant.
    for (int k = 0; k < 6; k++) begin
      step(333);
      exp_tag = "R7";
    end
    // R8: field order of the output ports.
    @(negedge clk);
    check("R8", {mant, bexp, eexp}, DEF_DATA[ref_row(333)]);
    check("R8", {54'(0), mant}, {54'(0), DEF_DATA[ref_row(333)][DW-1 -: DEF_MANT_W]});

    // R1: asynchronous clear mid-run.
    addr = AW'(900);
    @(posedge clk);
    #2 rst_n = 1'b0;
    #1 check("R1", {mant, bexp, eexp}, '0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    exp_word = DEF_DATA[ref_row(900)];
    exp_tag  = "R2";
    step(1023);
    step(0);
    step(int'(DEF_START[4]));
    @(negedge clk);
    check(exp_tag, {mant, bexp, eexp}, exp_word);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule